// File: doc/BRIEF.md
# In-band XON/XOFF Flow Control Engine

This block handles character-based flow control for a single UART channel. It watches every byte that the receive shifter delivers, removes bytes that match the selected "stop" or "resume" characters, and keeps a pause flag that holds back the local data transmitter. On the transmit side, the local receive buffer raises stop or resume requests. The block turns each request into one control character, or an ordered pair of them, and offers it to the transmit shifter ahead of any data byte.

Four 8-bit control characters are programmed through a small write-only port: two resume characters (set A, set B) and two stop characters (set A, set B). A 4-bit mode word has two halves. The upper two bits choose what the transmitter sends and the lower two bits choose what the receiver recognises. The receiver can compare against set A only, set B only, either set as single bytes, or the ordered two-byte sequence A then B. Serial shifting, baud timing and host register decoding are handled outside this block.

Top module: `inband_flow_ctrl`

## Requirements
- R1: After reset, fifo_wr and ctrl_valid are 0, tx_paused is 0, tx_data_ok is 1, and all four control characters hold 0x00.
- R2: With receive half (mode_sel[1:0]) 2'b10, a byte equal to stop-A sets tx_paused and a byte equal to resume-A clears it. With 2'b01, stop-B and resume-B do the same. A matched byte never reaches fifo_wr.
- R3: With receive half 2'b11 and transmit half (mode_sel[3:2]) 2'b10 or 2'b01, either stop character pauses and either resume character resumes, each as a single byte, and the byte is consumed.
- R4: With receive half 2'b11 and transmit half 2'b00 or 2'b11, only stop-A followed by stop-B pauses, and only resume-A followed by resume-B resumes. A lone first byte changes nothing and produces no write while it waits. The stop test on the first byte takes priority over the resume test.
- R5: In the two-byte mode, a first byte followed by any byte that does not complete its sequence writes both bytes as data in arrival order. The held byte is written one cycle after the second byte arrives, and the second byte one cycle later.
- R6: Every byte that is not consumed is written unchanged on fifo_data with fifo_wr one cycle after rx_valid. With receive half 2'b00, every byte passes.
- R7: While the receive half is 2'b00, tx_paused is 0 in that same cycle, and the stored pause is cleared.
- R8: A stop request offers ctrl_valid with stop-A when the transmit half is 2'b10 and stop-B when it is 2'b01. A resume request does the same with resume-A and resume-B. The offered character is held until ctrl_taken.
- R9: With transmit half 2'b11, a request offers the A character, and after ctrl_taken offers the B character. ctrl_valid drops after the second ctrl_taken.
- R10: A stop request cancels a pending resume (including one halfway through a pair) and restarts at the A character. A resume request does the same to a pending stop. A stop wins over a simultaneous resume. A request of the kind already pending is ignored. With transmit half 2'b00, requests are ignored and any pending insertion is dropped the next cycle.
- R11: tx_data_ok is 1 only when ctrl_valid is 0 and tx_paused is 0, so a control character always goes before the next data byte.
- R12: char_wr_sel selects the register written on char_wr_en: 0 resume-A, 1 resume-B, 2 stop-A, 3 stop-B. A new value is used for matching and insertion from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 4 | [3:2] transmit half, [1:0] receive half |
| char_wr_en | input | 1 | Write strobe for the control-character registers |
| char_wr_sel | input | 2 | Register select (0 resume-A, 1 resume-B, 2 stop-A, 3 stop-B) |
| char_wr_data | input | 8 | Value to write |
| rx_valid | input | 1 | Received byte strobe from the receive shifter |
| rx_byte | input | 8 | Received byte |
| fifo_wr | output | 1 | Data byte write toward the receive FIFO |
| fifo_data | output | 8 | Data byte |
| tx_paused | output | 1 | Peer asked to stop; data transmitter must hold |
| stop_req | input | 1 | Local receive buffer asks the peer to stop |
| go_req | input | 1 | Local receive buffer asks the peer to resume |
| ctrl_taken | input | 1 | Transmit shifter accepted the offered control character |
| ctrl_valid | output | 1 | A control character is offered |
| ctrl_byte | output | 8 | Offered control character |
| tx_data_ok | output | 1 | Transmit shifter may load the next data byte |

## Verification
Two events can land in the same cycle: a request and the acceptance of the character being offered. The bench sets this up with a resume pair whose A byte has already been taken. It then raises a stop request in the very cycle ctrl_taken accepts the B byte, and expects stop-A to be offered next rather than an idle state. On the receive side, a paused state can meet a pending insertion. Here tx_data_ok must stay low until both have cleared. Each byte value is also swept under all sixteen mode words against an arithmetic model of consumption and pass-through.

// File: rtl/swfc_pkg.sv
package swfc_pkg;

   localparam int NUM_CHARS = 4;
   localparam int SEL_W     = $clog2(NUM_CHARS);

   // index of each programmable control character
   typedef enum logic [SEL_W-1:0] {
      CH_ON_A  = 2'd0,
      CH_ON_B  = 2'd1,
      CH_OFF_A = 2'd2,
      CH_OFF_B = 2'd3
   } char_id_e;

   // encoding of one half of the mode word
   typedef enum logic [1:0] {
      SIDE_OFF  = 2'b00,
      SIDE_B    = 2'b01,
      SIDE_A    = 2'b10,
      SIDE_BOTH = 2'b11
   } side_mode_e;

   typedef enum logic [1:0] {
      INS_NONE = 2'd0,
      INS_ON   = 2'd1,
      INS_OFF  = 2'd2
   } ins_kind_e;

endpackage

// File: rtl/swfc_char_bank.sv
module swfc_char_bank
   import swfc_pkg::*;
#(
   parameter int CHAR_W = 8,
   parameter logic [CHAR_W-1:0] RESET_VAL = '0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [SEL_W-1:0]                wr_sel,
   input  logic [CHAR_W-1:0]               wr_data,
   output logic [NUM_CHARS-1:0][CHAR_W-1:0] chars
);

   generate
      for (genvar i = 0; i < NUM_CHARS; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chars[i] <= RESET_VAL;
            else if (wr_en && (wr_sel == SEL_W'(i)))
               chars[i] <= wr_data;
         end
      end
   endgenerate

endmodule

// File: rtl/swfc_rx_matcher.sv
module swfc_rx_matcher
   import swfc_pkg::*;
#(
   parameter int CHAR_W = 8,
   parameter bit SEQ_EN = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [1:0]                      rx_mode,
   input  logic [1:0]                      tx_mode,
   input  logic [NUM_CHARS-1:0][CHAR_W-1:0] chars,
   input  logic                            rx_valid,
   input  logic [CHAR_W-1:0]               rx_byte,
   output logic                            fifo_wr,
   output logic [CHAR_W-1:0]               fifo_data,
   output logic                            paused
);

   logic              rx_en, seq_mode;
   logic              on_a, on_b, off_a, off_b, hit_on, hit_off;
   logic              hold_q, hold_n, hkind_q, hkind_n;
   logic [CHAR_W-1:0] hbyte_q, hbyte_n;
   logic              flush_q, flush_n;
   logic [CHAR_W-1:0] fbyte_q, fbyte_n;
   logic              pause_q, pause_n;
   logic              wr_n;
   logic [CHAR_W-1:0] data_n;

   assign rx_en = (rx_mode != SIDE_OFF);

   generate
      if (SEQ_EN) begin : g_seq
         assign seq_mode = (rx_mode == SIDE_BOTH) &&
                           ((tx_mode == SIDE_OFF) || (tx_mode == SIDE_BOTH));
      end else begin : g_noseq
         assign seq_mode = 1'b0;
      end
   endgenerate

   assign on_a  = (rx_byte == chars[CH_ON_A]);
   assign on_b  = (rx_byte == chars[CH_ON_B]);
   assign off_a = (rx_byte == chars[CH_OFF_A]);
   assign off_b = (rx_byte == chars[CH_OFF_B]);

   // single-byte compare sets
   always_comb begin
      unique case (rx_mode)
         SIDE_A:  begin hit_on = on_a;        hit_off = off_a;         end
         SIDE_B:  begin hit_on = on_b;        hit_off = off_b;         end
         SIDE_BOTH: begin hit_on = on_a | on_b; hit_off = off_a | off_b; end
         default: begin hit_on = 1'b0;        hit_off = 1'b0;          end
      endcase
   end

   always_comb begin
      wr_n    = 1'b0;
      data_n  = fifo_data;
      hold_n  = hold_q;
      hkind_n = hkind_q;
      hbyte_n = hbyte_q;
      flush_n = 1'b0;
      fbyte_n = fbyte_q;
      pause_n = pause_q;

      // second half of a broken pair
      if (flush_q) begin
         wr_n   = 1'b1;
         data_n = fbyte_q;
      end
      // mode left the two-byte compare while a first byte waited
      if (hold_q && !seq_mode) begin
         wr_n   = 1'b1;
         data_n = hbyte_q;
         hold_n = 1'b0;
      end

      if (rx_valid) begin
         if (!rx_en) begin
            wr_n   = 1'b1;
            data_n = rx_byte;
         end else if (seq_mode) begin
            if (hold_q) begin
               hold_n = 1'b0;
               if (hkind_q && off_b)
                  pause_n = 1'b1;
               else if (!hkind_q && on_b)
                  pause_n = 1'b0;
               else begin
                  wr_n    = 1'b1;
                  data_n  = hbyte_q;
                  flush_n = 1'b1;
                  fbyte_n = rx_byte;
               end
            end else if (off_a) begin
               hold_n  = 1'b1;
               hkind_n = 1'b1;
               hbyte_n = rx_byte;
            end else if (on_a) begin
               hold_n  = 1'b1;
               hkind_n = 1'b0;
               hbyte_n = rx_byte;
            end else begin
               wr_n   = 1'b1;
               data_n = rx_byte;
            end
         end else begin
            if (hit_off)
               pause_n = 1'b1;
            else if (hit_on)
               pause_n = 1'b0;
            else begin
               wr_n   = 1'b1;
               data_n = rx_byte;
            end
         end
      end

      if (!rx_en)
         pause_n = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= 1'b0;
         hkind_q   <= 1'b0;
         hbyte_q   <= '0;
         flush_q   <= 1'b0;
         fbyte_q   <= '0;
         pause_q   <= 1'b0;
         fifo_wr   <= 1'b0;
         fifo_data <= '0;
      end else begin
         hold_q    <= hold_n;
         hkind_q   <= hkind_n;
         hbyte_q   <= hbyte_n;
         flush_q   <= flush_n;
         fbyte_q   <= fbyte_n;
         pause_q   <= pause_n;
         fifo_wr   <= wr_n;
         fifo_data <= data_n;
      end
   end

   // receive half off masks the stored pause in the same cycle
   assign paused = pause_q & rx_en;

endmodule

// File: rtl/swfc_tx_inserter.sv
module swfc_tx_inserter
   import swfc_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [1:0]                      tx_mode,
   input  logic [NUM_CHARS-1:0][CHAR_W-1:0] chars,
   input  logic                            stop_req,
   input  logic                            go_req,
   input  logic                            ctrl_taken,
   output logic                            ctrl_valid,
   output logic [CHAR_W-1:0]               ctrl_byte
);

   ins_kind_e kind_q, kind_n;
   logic      idx_q, idx_n;
   logic      pair, use_b;

   assign pair = (tx_mode == SIDE_BOTH);

   always_comb begin
      kind_n = kind_q;
      idx_n  = idx_q;
      if (tx_mode == SIDE_OFF) begin
         kind_n = INS_NONE;
         idx_n  = 1'b0;
      end else if (stop_req && (kind_q != INS_OFF)) begin
         kind_n = INS_OFF;
         idx_n  = 1'b0;
      end else if (go_req && !stop_req && (kind_q != INS_ON)) begin
         kind_n = INS_ON;
         idx_n  = 1'b0;
      end else if (ctrl_taken && (kind_q != INS_NONE)) begin
         if (pair && !idx_q)
            idx_n = 1'b1;
         else begin
            kind_n = INS_NONE;
            idx_n  = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= INS_NONE;
         idx_q  <= 1'b0;
      end else begin
         kind_q <= kind_n;
         idx_q  <= idx_n;
      end
   end

   assign use_b      = (tx_mode == SIDE_B) || (pair && idx_q);
   assign ctrl_valid = (kind_q != INS_NONE);

   always_comb begin
      if (kind_q == INS_OFF)
         ctrl_byte = use_b ? chars[CH_OFF_B] : chars[CH_OFF_A];
      else
         ctrl_byte = use_b ? chars[CH_ON_B] : chars[CH_ON_A];
   end

endmodule

// File: rtl/inband_flow_ctrl.sv
module inband_flow_ctrl
   import swfc_pkg::*;
#(
   parameter int CHAR_W = 8,
   parameter logic [CHAR_W-1:0] CHAR_RESET = '0,
   parameter bit SEQ_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        mode_sel,
   input  logic              char_wr_en,
   input  logic [1:0]        char_wr_sel,
   input  logic [CHAR_W-1:0] char_wr_data,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_byte,
   output logic              fifo_wr,
   output logic [CHAR_W-1:0] fifo_data,
   output logic              tx_paused,
   input  logic              stop_req,
   input  logic              go_req,
   input  logic              ctrl_taken,
   output logic              ctrl_valid,
   output logic [CHAR_W-1:0] ctrl_byte,
   output logic              tx_data_ok
);

   generate
      if (CHAR_W < 5 || CHAR_W > 9) begin : g_bad_width
         $error("inband_flow_ctrl: CHAR_W must lie in 5..9");
      end
      if (SEL_W != 2) begin : g_bad_sel
         $error("inband_flow_ctrl: select width must be 2");
      end
   endgenerate

   logic [NUM_CHARS-1:0][CHAR_W-1:0] chars;
   logic [1:0] tx_mode, rx_mode;

   assign tx_mode = mode_sel[3:2];
   assign rx_mode = mode_sel[1:0];

   swfc_char_bank #(.CHAR_W(CHAR_W), .RESET_VAL(CHAR_RESET)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (char_wr_en),
      .wr_sel  (char_wr_sel),
      .wr_data (char_wr_data),
      .chars   (chars)
   );

   swfc_rx_matcher #(.CHAR_W(CHAR_W), .SEQ_EN(SEQ_EN)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_mode   (rx_mode),
      .tx_mode   (tx_mode),
      .chars     (chars),
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .fifo_wr   (fifo_wr),
      .fifo_data (fifo_data),
      .paused    (tx_paused)
   );

   swfc_tx_inserter #(.CHAR_W(CHAR_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_mode    (tx_mode),
      .chars      (chars),
      .stop_req   (stop_req),
      .go_req     (go_req),
      .ctrl_taken (ctrl_taken),
      .ctrl_valid (ctrl_valid),
      .ctrl_byte  (ctrl_byte)
   );

   assign tx_data_ok = !ctrl_valid && !tx_paused;

endmodule

// File: rtl/inband_flow_ctrl_chk.sv
module inband_flow_ctrl_chk #(
   parameter int CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        mode_sel,
   input logic              rx_valid,
   input logic [CHAR_W-1:0] rx_byte,
   input logic              fifo_wr,
   input logic [CHAR_W-1:0] fifo_data,
   input logic              tx_paused,
   input logic              stop_req,
   input logic              go_req,
   input logic              ctrl_taken,
   input logic              ctrl_valid,
   input logic              tx_data_ok
);

   // R7
   rx_off_unpaused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel[1:0] == 2'b00) |-> !tx_paused);

   // R10
   tx_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel[3:2] == 2'b00) |=> !ctrl_valid);

   // R8
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_valid && !ctrl_taken && !stop_req && !go_req && mode_sel[3:2] != 2'b00)
      |=> ctrl_valid);

   // R11
   ctrl_blocks_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_valid || tx_paused) |-> !tx_data_ok);

   // R6
   passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && mode_sel[1:0] == 2'b00 && $past(mode_sel[1:0]) == 2'b00)
      |=> (fifo_wr && fifo_data == $past(rx_byte)));

endmodule

bind inband_flow_ctrl inband_flow_ctrl_chk #(.CHAR_W(CHAR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_sel   (mode_sel),
   .rx_valid   (rx_valid),
   .rx_byte    (rx_byte),
   .fifo_wr    (fifo_wr),
   .fifo_data  (fifo_data),
   .tx_paused  (tx_paused),
   .stop_req   (stop_req),
   .go_req     (go_req),
   .ctrl_taken (ctrl_taken),
   .ctrl_valid (ctrl_valid),
   .tx_data_ok (tx_data_ok)
);

// File: tb/tb_inband_flow_ctrl.sv
module tb_inband_flow_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   mode_sel = '0;
   logic         char_wr_en = 1'b0;
   logic [1:0]   char_wr_sel = '0;
   logic [W-1:0] char_wr_data = '0;
   logic         rx_valid = 1'b0;
   logic [W-1:0] rx_byte = '0;
   logic         fifo_wr;
   logic [W-1:0] fifo_data;
   logic         tx_paused;
   logic         stop_req = 1'b0;
   logic         go_req = 1'b0;
   logic         ctrl_taken = 1'b0;
   logic         ctrl_valid;
   logic [W-1:0] ctrl_byte;
   logic         tx_data_ok;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   // bench model: c[0] resume-A, c[1] resume-B, c[2] stop-A, c[3] stop-B
   logic [W-1:0] c [4];
   bit           m_paused = 1'b0;
   bit           m_hold = 1'b0;
   bit           m_hkind = 1'b0;
   logic [W-1:0] m_hbyte = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   inband_flow_ctrl #(.CHAR_W(W)) dut (
      .clk (clk), .rst_n (rst_n), .mode_sel (mode_sel),
      .char_wr_en (char_wr_en), .char_wr_sel (char_wr_sel), .char_wr_data (char_wr_data),
      .rx_valid (rx_valid), .rx_byte (rx_byte),
      .fifo_wr (fifo_wr), .fifo_data (fifo_data), .tx_paused (tx_paused),
      .stop_req (stop_req), .go_req (go_req), .ctrl_taken (ctrl_taken),
      .ctrl_valid (ctrl_valid), .ctrl_byte (ctrl_byte), .tx_data_ok (tx_data_ok)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic set_mode(input logic [3:0] m);
      @(negedge clk);
      mode_sel = m;
      if (m[1:0] == 2'b00) m_paused = 1'b0;
   endtask

   task automatic wr_char(input logic [1:0] sel, input logic [W-1:0] v);
      @(negedge clk);
      char_wr_en = 1'b1; char_wr_sel = sel; char_wr_data = v;
      c[sel] = v;
      @(negedge clk);
      char_wr_en = 1'b0;
   endtask

   task automatic send_byte(input logic [W-1:0] b);
      logic [W-1:0] e [2];
      logic [W-1:0] g [3];
      int ne = 0;
      int ng = 0;
      string tg;
      logic [1:0] rm = mode_sel[1:0];
      logic [1:0] tm = mode_sel[3:2];
      bit seq = (rm == 2'b11) && (tm == 2'b00 || tm == 2'b11);
      bit hon, hoff;
      if (rm == 2'b00) begin
         tg = "R6"; e[0] = b; ne = 1;
      end else if (seq) begin
         tg = "R4";
         if (m_hold) begin
            m_hold = 1'b0;
            if (m_hkind && b == c[3]) m_paused = 1'b1;
            else if (!m_hkind && b == c[1]) m_paused = 1'b0;
            else begin tg = "R5"; e[0] = m_hbyte; e[1] = b; ne = 2; end
         end else if (b == c[2]) begin
            m_hold = 1'b1; m_hkind = 1'b1; m_hbyte = b;
         end else if (b == c[0]) begin
            m_hold = 1'b1; m_hkind = 1'b0; m_hbyte = b;
         end else begin
            tg = "R6"; e[0] = b; ne = 1;
         end
      end else begin
         tg = (rm == 2'b11) ? "R3" : "R2";
         hoff = (rm == 2'b10) ? (b == c[2]) : (rm == 2'b01) ? (b == c[3]) : (b == c[2] || b == c[3]);
         hon  = (rm == 2'b10) ? (b == c[0]) : (rm == 2'b01) ? (b == c[1]) : (b == c[0] || b == c[1]);
         if (hoff) m_paused = 1'b1;
         else if (hon) m_paused = 1'b0;
         else begin e[0] = b; ne = 1; end
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (k == 0) rx_valid = 1'b0;
         if (fifo_wr) begin
            if (ng < 3) g[ng] = fifo_data;
            ng++;
         end
      end
      check(ng == ne, {tg, " write count"}, ng, ne);
      for (int i = 0; i < ne; i++)
         if (i < ng) check(g[i] == e[i], {tg, " write data"}, g[i], e[i]);
      check(tx_paused == (m_paused && rm != 2'b00), {tg, " pause flag"}, tx_paused, m_paused);
   endtask

   task automatic tx_cycle(input bit s, input bit g, input bit t);
      @(negedge clk);
      stop_req = s; go_req = g; ctrl_taken = t;
      @(negedge clk);
      stop_req = 1'b0; go_req = 1'b0; ctrl_taken = 1'b0;
   endtask

   task automatic exp_ctrl(input bit v, input logic [W-1:0] b, input string tag);
      check(ctrl_valid == v, {tag, " ctrl_valid"}, ctrl_valid, v);
      if (v) check(ctrl_byte == b, {tag, " ctrl_byte"}, ctrl_byte, b);
      // R11
      check(tx_data_ok == (!v && !tx_paused), "R11 tx_data_ok", tx_data_ok, !v && !tx_paused);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) c[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(fifo_wr == 1'b0, "R1 fifo_wr", fifo_wr, 0);
      check(ctrl_valid == 1'b0, "R1 ctrl_valid", ctrl_valid, 0);
      check(tx_paused == 1'b0, "R1 tx_paused", tx_paused, 0);
      check(tx_data_ok == 1'b1, "R1 tx_data_ok", tx_data_ok, 1);
      // R1 R12: reset characters are 0x00, so 0x00 is stop-A in mode 0010
      set_mode(4'b0010);
      send_byte(8'h00);
      check(tx_paused == 1'b1, "R1 reset char", tx_paused, 1);
      // R7: receive half off clears pause within the same cycle
      @(negedge clk);
      mode_sel = 4'b0000; m_paused = 1'b0;
      #1;
      check(tx_paused == 1'b0, "R7 immediate clear", tx_paused, 0);

      // R12 program by select encoding
      wr_char(2'd0, 8'h11);
      wr_char(2'd1, 8'h12);
      wr_char(2'd2, 8'h13);
      wr_char(2'd3, 8'h14);

      // R2 R3 R4 R5 R6: full byte sweep under every mode word
      for (int m = 0; m < 16; m++) begin
         set_mode(4'(m));
         for (int b = 0; b < 256; b++) begin
            send_byte(8'(b));
            if (m_hold) send_byte(8'hA5);
         end
      end

      // R4 explicit pairs, both halves 11
      set_mode(4'b1111);
      send_byte(8'h13); send_byte(8'h14);
      check(tx_paused == 1'b1, "R4 stop pair", tx_paused, 1);
      send_byte(8'h11); send_byte(8'h12);
      check(tx_paused == 1'b0, "R4 resume pair", tx_paused, 0);
      // R5 broken pair whose second byte is itself a first byte
      send_byte(8'h13); send_byte(8'h11);
      send_byte(8'h11); send_byte(8'h14);
      // R7 with pause held
      set_mode(4'b0001);
      send_byte(8'h14);
      set_mode(4'b0000);
      #1;
      check(tx_paused == 1'b0, "R7 clear", tx_paused, 0);

      // R12 overwrite resume-A
      wr_char(2'd0, 8'h55);
      set_mode(4'b0010);
      send_byte(8'h13);
      send_byte(8'h11);
      send_byte(8'h55);
      check(tx_paused == 1'b0, "R12 new resume-A", tx_paused, 0);
      wr_char(2'd0, 8'h11);

      // R8 single insertion
      set_mode(4'b1000);
      tx_cycle(1, 0, 0); exp_ctrl(1, 8'h13, "R8 stop A");
      tx_cycle(0, 0, 0); exp_ctrl(1, 8'h13, "R8 held");
      tx_cycle(0, 0, 1); exp_ctrl(0, 8'h00, "R8 done");
      set_mode(4'b0100);
      tx_cycle(1, 0, 0); exp_ctrl(1, 8'h14, "R8 stop B");
      tx_cycle(0, 0, 1); exp_ctrl(0, 8'h00, "R8 done B");
      tx_cycle(0, 1, 0); exp_ctrl(1, 8'h12, "R8 go B");
      tx_cycle(0, 0, 1); exp_ctrl(0, 8'h00, "R8 done go");

      // R9 pair order
      set_mode(4'b1100);
      tx_cycle(1, 0, 0); exp_ctrl(1, 8'h13, "R9 first");
      tx_cycle(0, 0, 1); exp_ctrl(1, 8'h14, "R9 second");
      tx_cycle(0, 0, 1); exp_ctrl(0, 8'h00, "R9 end");
      tx_cycle(0, 1, 0); exp_ctrl(1, 8'h11, "R9 go first");
      tx_cycle(0, 0, 1); exp_ctrl(1, 8'h12, "R9 go second");
      tx_cycle(0, 0, 1); exp_ctrl(0, 8'h00, "R9 go end");

      // R10 cancel and collision cases
      tx_cycle(0, 1, 0); exp_ctrl(1, 8'h11, "R10 go");
      tx_cycle(1, 0, 0); exp_ctrl(1, 8'h13, "R10 stop cancels go");
      tx_cycle(0, 0, 1); exp_ctrl(1, 8'h14, "R10 stop second");
      tx_cycle(1, 0, 0); exp_ctrl(1, 8'h14, "R10 same kind ignored");
      tx_cycle(0, 1, 0); exp_ctrl(1, 8'h11, "R10 go replaces stop");
      tx_cycle(0, 0, 1); exp_ctrl(1, 8'h12, "R10 go half sent");
      tx_cycle(1, 0, 1); exp_ctrl(1, 8'h13, "R10 stop with taken");
      tx_cycle(1, 1, 0); exp_ctrl(1, 8'h13, "R10 stop beats go");
      tx_cycle(0, 0, 1); tx_cycle(0, 0, 1); exp_ctrl(0, 8'h00, "R10 drained");
      set_mode(4'b0000);
      tx_cycle(1, 0, 0); exp_ctrl(0, 8'h00, "R10 tx off ignores");
      set_mode(4'b1000);
      tx_cycle(1, 0, 0); exp_ctrl(1, 8'h13, "R10 pending");
      set_mode(4'b0000);
      @(negedge clk);
      exp_ctrl(0, 8'h00, "R10 tx off drops");

      // R11 pause and pending insertion together
      set_mode(4'b1010);
      send_byte(8'h13);
      tx_cycle(0, 1, 0); exp_ctrl(1, 8'h11, "R11 both");
      tx_cycle(0, 0, 1); exp_ctrl(0, 8'h00, "R11 paused only");
      check(tx_data_ok == 1'b0, "R11 paused blocks", tx_data_ok, 0);
      send_byte(8'h11);
      exp_ctrl(0, 8'h00, "R11 clear");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule